// File: doc/BRIEF.md
# Wake-Up Interrupt Generator

This block watches a small set of slow single-bit inputs, such as buttons or status lines, and produces one merged active-low interrupt that wakes a sleeping microcontroller. There are two kinds of channel. Bidirectional channels fire on every level change. Falling-only channels fire only when the input drops from high to low, and ignore rising transitions.

The design is fully synchronous. Each raw input passes through a two-stage synchronizer. The synchronized level is then compared with a registered copy of its previous value. The per-channel hits are merged into one event. That event loads a down-counter, and the output stays low while the counter is non-zero. A new event during an active pulse reloads the counter, so the low period is extended rather than split. Detection is held off until the synchronizer has refilled after reset, so leaving reset never produces a pulse by itself.

Top module: `wake_irq_gen`

## Requirements
- R1: After reset is released with stable inputs, `irq_n` is high, and it stays high for as long as no input changes.
- R2: A level change in either direction on any bit of `any_in` makes `irq_n` go low. If the first rising clock edge that samples the new level is edge e, `irq_n` is low right after edge e+2 and still high right after edge e+1.
- R3: A high-to-low change on any bit of `fall_in` makes `irq_n` go low, with the same latency as in R2.
- R4: A low-to-high change on a bit of `fall_in` has no effect: `irq_n` stays high.
- R5: A single event holds `irq_n` low for exactly `PULSE_CYCLES` clock cycles. It then returns high.
- R6: An event that reaches the output stage while `irq_n` is low reloads the count. `irq_n` then stays low for `PULSE_CYCLES` cycles counted from the reload, with no high gap in between.
- R7: Events on several inputs that are sampled at the same clock edge give one low pulse of `PULSE_CYCLES` cycles.
- R8: When `rst` is high at a clock edge, `irq_n` is high after that edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| any_in | input | N_ANY | Raw asynchronous inputs that trigger on either edge |
| fall_in | input | N_FALL | Raw asynchronous inputs that trigger only on a falling edge |
| irq_n | output | 1 | Merged active-low wake interrupt |

## Verification
The bench builds the block with `PULSE_CYCLES` = 3 and two channels of each kind. The short pulse means that a second event placed exactly when the output first goes low arrives before the count expires, so the reload path can be tested without a high gap. With two channels per kind, simultaneous events on several bidirectional and falling-only channels can be mixed. Random toggling on all four inputs then makes overlapping pulses, reloads near expiry and ignored rising edges happen many times within a short run.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic level;
        logic hit;
    } chan_obs_t;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic diff;
        diff = prev ^ cur;
        return (mode == EDGE_FALL) ? (diff & ~cur) : diff;
    endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/wk_edge_chan.sv
module wk_edge_chan
    import wake_irq_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_ANY
) (
    input  logic      clk,
    input  logic      armed,
    input  logic      level,
    output chan_obs_t obs
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= level;
    end

    always_comb begin
        obs.level = level;
        obs.hit   = armed & edge_hit(MODE, prev_q, level);
    end
endmodule

// File: rtl/wk_arm.sv
module wk_arm #(
    parameter int FILL = 2
) (
    input  logic clk,
    input  logic rst,
    output logic armed
);
    localparam int FW = $clog2(FILL + 1);

    logic [FW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (fill_q != FW'(FILL)) begin
            fill_q <= fill_q + FW'(1);
        end
    end

    assign armed = (fill_q == FW'(FILL));
endmodule

// File: rtl/wk_stretch.sv
module wk_stretch #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic irq_n
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CW'(PULSE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign irq_n = (cnt_q == '0);
endmodule

// File: rtl/wake_irq_gen.sv
module wake_irq_gen
    import wake_irq_pkg::*;
#(
    parameter int N_ANY        = 2,
    parameter int N_FALL       = 2,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ANY-1:0]  any_in,
    input  logic [N_FALL-1:0] fall_in,
    output logic              irq_n
);
    localparam int N_CH = N_ANY + N_FALL;

    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] lvl_sync;
    logic [N_CH-1:0] hits;
    logic            armed;
    logic            ev_any;
    chan_obs_t       obs [N_CH];

    assign raw = {fall_in, any_in};

    wk_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (raw),
        .dout (lvl_sync)
    );

    wk_arm #(.FILL(SYNC_STAGES)) u_arm (
        .clk   (clk),
        .rst   (rst),
        .armed (armed)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        localparam edge_mode_e CH_MODE = (ch < N_ANY) ? EDGE_ANY : EDGE_FALL;
        wk_edge_chan #(.MODE(CH_MODE)) u_chan (
            .clk   (clk),
            .armed (armed),
            .level (lvl_sync[ch]),
            .obs   (obs[ch])
        );
        assign hits[ch] = obs[ch].hit;
    end

    assign ev_any = |hits;

    wk_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
        .clk   (clk),
        .rst   (rst),
        .trig  (ev_any),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/wake_irq_gen_chk.sv
module wake_irq_gen_chk #(
    parameter int N_ANY        = 2,
    parameter int N_FALL       = 2,
    parameter int PULSE_CYCLES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    irq_n,
    input logic                    ev_any,
    input logic [N_ANY+N_FALL-1:0] lvl,
    input logic [N_ANY+N_FALL-1:0] hits
);
    localparam int N_CH = N_ANY + N_FALL;
    localparam int SW   = $clog2(PULSE_CYCLES + 2);
    localparam logic [N_CH-1:0] FALL_MASK = {N_CH{1'b1}} << N_ANY;

    logic [SW-1:0] since_q;
    logic          in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (ev_any) begin
            since_q <= SW'(1);
        end else if (since_q != '0 && since_q <= SW'(PULSE_CYCLES)) begin
            since_q <= since_q + SW'(1);
        end
    end

    assign in_window = (since_q != '0) && (since_q <= SW'(PULSE_CYCLES));

    assert_reset_idle_R8: assert property (@(posedge clk) rst |=> irq_n);

    assert_fall_only_R4: assert property (@(posedge clk) disable iff (rst)
        ((hits & lvl & FALL_MASK) == '0));

    assert_low_window_R5: assert property (@(posedge clk) disable iff (rst)
        in_window |-> !irq_n);

    assert_high_outside_R5: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> irq_n);

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        ev_any |=> !irq_n);

    assert_fall_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(ev_any));
endmodule

bind wake_irq_gen wake_irq_gen_chk #(
    .N_ANY        (N_ANY),
    .N_FALL       (N_FALL),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq_n  (irq_n),
    .ev_any (ev_any),
    .lvl    (lvl_sync),
    .hits   (hits)
);

// File: tb/wake_irq_gen_bench.sv
module wake_irq_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_ANY      = 2;
    localparam int N_FALL     = 2;
    localparam int P          = 3;
    localparam int N_CH       = N_ANY + N_FALL;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_ANY-1:0]  any_in = '0;
    logic [N_FALL-1:0] fall_in = '1;
    logic              irq_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_en   = 0;
    bit    done     = 0;
    string tag      = "R1";

    logic [N_CH-1:0] hist [$];
    int m_cnt = 0;
    int post  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_irq_gen #(.N_ANY(N_ANY), .N_FALL(N_FALL), .PULSE_CYCLES(P)) u_wake_irq_gen (
        .clk     (clk),
        .rst     (rst),
        .any_in  (any_in),
        .fall_in (fall_in),
        .irq_n   (irq_n)
    );

    function automatic bit qualifies(logic [N_CH-1:0] nw, logic [N_CH-1:0] od);
        for (int i = 0; i < N_CH; i++) begin
            if (nw[i] != od[i] && (i < N_ANY || nw[i] == 1'b0)) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) hist.push_front({fall_in, any_in});
    end

    // reference model: history of sampled raw levels plus a pulse counter
    always @(posedge clk) begin
        hist.push_front({fall_in, any_in});
        if (hist.size() > 4) void'(hist.pop_back());
        if (rst) begin
            m_cnt = 0;
            post  = 0;
        end else begin
            post++;
            if (post >= 3 && qualifies(hist[2], hist[3])) m_cnt = P;
            else if (m_cnt > 0) m_cnt--;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) check(irq_n === (m_cnt == 0), tag, int'(irq_n), int'(m_cnt == 0));
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(int n, output int lows, output int falls);
        logic last;
        lows = 0; falls = 0; last = irq_n;
        repeat (n) begin
            @(negedge clk);
            if (irq_n == 1'b0) lows++;
            if (last == 1'b1 && irq_n == 1'b0) falls++;
            last = irq_n;
        end
    endtask

    initial begin
        int lows, falls;
        step(5);
        rst = 1'b0;
        cmp_en = 1;
        tag = "R1";
        step(1);
        check(irq_n === 1'b1, "R1 reset idle", int'(irq_n), 1);
        window(8, lows, falls);
        check(lows == 0, "R1 no pulse from reset", lows, 0);

        // R2 rising then falling on a bidirectional input
        tag = "R2";
        any_in[0] = 1'b1;
        step(2);
        check(irq_n === 1'b1, "R2 before latency", int'(irq_n), 1);
        step(1);
        check(irq_n === 1'b0, "R2 rise latency", int'(irq_n), 0);
        step(10);
        any_in[0] = 1'b0;
        step(2);
        check(irq_n === 1'b1, "R2 before latency fall", int'(irq_n), 1);
        step(1);
        check(irq_n === 1'b0, "R2 fall latency", int'(irq_n), 0);
        step(10);

        // R3 falling edge on a falling-only input
        tag = "R3";
        fall_in[0] = 1'b0;
        step(2);
        check(irq_n === 1'b1, "R3 before latency", int'(irq_n), 1);
        step(1);
        check(irq_n === 1'b0, "R3 fall triggers", int'(irq_n), 0);
        step(10);

        // R4 rising edge on a falling-only input is ignored
        tag = "R4";
        fall_in[0] = 1'b1;
        window(10, lows, falls);
        check(lows == 0, "R4 rise ignored", lows, 0);

        // R5 exact pulse length
        tag = "R5";
        any_in[1] = 1'b1;
        window(12, lows, falls);
        check(lows == P, "R5 pulse length", lows, P);
        check(falls == 1, "R5 single pulse", falls, 1);

        // R6 reload while low
        tag = "R6";
        any_in[0] = 1'b1;
        step(3);
        check(irq_n === 1'b0, "R6 first low", int'(irq_n), 0);
        any_in[0] = 1'b0;
        window(15, lows, falls);
        check(lows == P + 2, "R6 extended low run", lows, P + 2);
        check(falls == 0, "R6 no high gap", falls, 0);

        // R7 simultaneous events merge
        tag = "R7";
        any_in     = ~any_in;
        fall_in[1] = 1'b0;
        window(12, lows, falls);
        check(lows == P, "R7 merged length", lows, P);
        check(falls == 1, "R7 one pulse", falls, 1);
        fall_in[1] = 1'b1;
        step(10);

        // R8 reset in the middle of a pulse
        tag = "R8";
        any_in[1] = ~any_in[1];
        step(3);
        check(irq_n === 1'b0, "R8 pulse started", int'(irq_n), 0);
        rst = 1'b1;
        step(1);
        check(irq_n === 1'b1, "R8 reset clears", int'(irq_n), 1);
        step(3);
        rst = 1'b0;
        window(8, lows, falls);
        check(lows == 0, "R8 quiet after reset", lows, 0);

        // random toggling on all inputs, compared every cycle with the model
        tag = "R2 R3 R4 R5 R6 R7 random";
        for (int k = 0; k < 3000; k++) begin
            for (int b = 0; b < N_ANY; b++)  if ($urandom_range(7) == 0) any_in[b]  = ~any_in[b];
            for (int b = 0; b < N_FALL; b++) if ($urandom_range(7) == 0) fall_in[b] = ~fall_in[b];
            step(1);
        end
        step(10);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (test did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule